// File: doc/BRIEF.md
# Prescaled Alarm Timer Channel

This block is one 64-bit timer channel. A programmable prescaler turns the core clock into count ticks. The counter moves by one on each tick, up or down. Software drives the channel through a small register port with one write strobe and a combinational read. From there it can start and stop counting, stage a value and copy it into the counter, set the divider, program a 64-bit alarm value, and arm the alarm with or without auto-reload. A level interrupt is raised when the counter meets the alarm. The raw status bit stays set until software clears it or initialises the channel.

The run and arm bits live in a four-state controller:

- `ST_HALT_IDLE` means stopped and disarmed.
- `ST_HALT_ARMED` means stopped and armed.
- `ST_RUN_FREE` means counting and disarmed.
- `ST_RUN_ARMED` means counting and armed.

The controller moves between these states in three ways, listed by priority:

1. An init write goes to `ST_HALT_IDLE`.
2. A control write goes to the state named by its run and arm bits.
3. An alarm hit in `ST_RUN_ARMED` goes to `ST_RUN_FREE`, because the arm bit clears itself.

Register map (address on `wr_addr`/`rd_addr`):

| Address | Access | Contents |
|---|---|---|
| 0 | read/write | Control: bit0 run, bit1 up (1) / down (0), bit2 alarm armed, bit3 auto-reload, bit4 interrupt enable |
| 1 | read/write | Divider field, 16 bits |
| 2 | read/write | Staged load value |
| 3 | write only | Any write copies the staged load value into the counter |
| 4 | read/write | Alarm value |
| 5 | read only | Live counter |
| 6 | read / write-1 | bit0 is the raw status; writing 1 to bit0 clears it |
| 7 | write only | Init: clears the status, stops, disarms and restarts the prescaler |

Every other address reads as 0.

Top module: `alarm_timer_chan`

## Requirements
- R1: The counter changes once every D core cycles, where D is the effective divide. The first change lands D cycles after the edge that sets the run bit.
- R2: A divider field of 0 divides by 65536. A field of 1 divides by 2. Any other field N divides by N.
- R3: A write to the divider register restarts the prescaler. The next counter change comes D_new cycles after that write edge.
- R4: While stopped, the counter holds its value. A value copied in through address 3 reads back unchanged at address 5.
- R5: With control bit1 at 0, the counter decrements by one per tick.
- R6: The alarm is evaluated only on tick cycles, against the value the counter is about to take. In up mode it hits when that value is >= the alarm value; in down mode when it is <= the alarm value. On a hit, status bit0 of address 6 is set on the same edge.
- R7: If auto-reload (control bit3) is set, the counter takes the staged load value on an alarm hit. If it is clear, the counter keeps counting past the alarm value.
- R8: The arm bit (control bit2) clears itself when the alarm hits. With the arm bit clear, no status is set.
- R9: The status bit stays set until a write of 1 to bit0 of address 6. An alarm hit in the same cycle as that clear leaves the bit set.
- R10: A write to address 7 clears the status bit, clears run and arm, and leaves the counter value where it was.
- R11: `irq` is high exactly while the status bit and interrupt enable (control bit4) are both set.
- R12: After reset, control reads 0x2 (up, stopped, disarmed), the divider field reads 2, the counter and status read 0, and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 64 | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | 64 | Read data, combinational from `rd_addr` |
| irq | output | 1 | Level interrupt |

## Verification
A wrong prescaler phase shows up at the counter read as a change one or more cycles early or late. The checks catch it within one divide period of the start, the divider write or the pause. A wrong state in the controller shows in several ways. A stuck arm bit reads back in the control register right after the hit, and it also produces a second status set once software clears the first. A lost priority between clear, hit and init shows in the status bit on the very next cycle. A wrong reload choice or compare direction shows at the counter read one cycle after the hit.

// File: rtl/atmr_pkg.sv
package atmr_pkg;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_CTRL    = 4'd0;
    localparam logic [ADDR_W-1:0] A_DIV     = 4'd1;
    localparam logic [ADDR_W-1:0] A_STAGE   = 4'd2;
    localparam logic [ADDR_W-1:0] A_COPY    = 4'd3;
    localparam logic [ADDR_W-1:0] A_ALARM   = 4'd4;
    localparam logic [ADDR_W-1:0] A_COUNT   = 4'd5;
    localparam logic [ADDR_W-1:0] A_STAT    = 4'd6;
    localparam logic [ADDR_W-1:0] A_INIT    = 4'd7;

    // control bit positions
    localparam int B_RUN    = 0;
    localparam int B_UP     = 1;
    localparam int B_ARM    = 2;
    localparam int B_RELOAD = 3;
    localparam int B_IEN    = 4;
    localparam int CTRL_W   = 5;

    typedef enum logic [1:0] {
        ST_HALT_IDLE  = 2'd0,
        ST_HALT_ARMED = 2'd1,
        ST_RUN_FREE   = 2'd2,
        ST_RUN_ARMED  = 2'd3
    } chan_state_e;
endpackage

// File: rtl/atmr_prescaler.sv
module atmr_prescaler #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [DIV_W-1:0] div_field,
    output logic             tick
);
    localparam int PC_W = DIV_W + 1;
    localparam logic [PC_W-1:0] MAX_DIV = {1'b1, {DIV_W{1'b0}}};
    localparam logic [PC_W-1:0] MIN_DIV = PC_W'(2);

    logic [PC_W-1:0] eff_div;
    logic [PC_W-1:0] phase;
    logic            wrap;

    // field 0 selects the largest divide, field 1 behaves as 2
    always_comb begin
        if (div_field == '0)
            eff_div = MAX_DIV;
        else if (div_field == DIV_W'(1))
            eff_div = MIN_DIV;
        else
            eff_div = {1'b0, div_field};
    end

    assign wrap = (phase == eff_div - PC_W'(1));
    assign tick = run && !restart && wrap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            phase <= '0;
        else if (restart || !run)
            phase <= '0;
        else if (wrap)
            phase <= '0;
        else
            phase <= phase + PC_W'(1);
    end

    AST_PHASE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        phase < eff_div); // R1

    AST_HALT_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!run || restart) |=> (phase == '0)); // R3
endmodule

// File: rtl/atmr_counter.sv
module atmr_counter #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             up,
    input  logic             fire,
    input  logic             reload_en,
    input  logic             copy_go,
    input  logic [CNT_W-1:0] stage_val,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_step
);
    assign cnt_step = up ? cnt_q + CNT_W'(1) : cnt_q - CNT_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (copy_go)
            cnt_q <= stage_val;
        else if (tick) begin
            if (fire && reload_en)
                cnt_q <= stage_val;
            else
                cnt_q <= cnt_step;
        end
    end

    AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !copy_go) |=> $stable(cnt_q)); // R4

    AST_RELOAD_TAKES_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && reload_en && !copy_go) |=> (cnt_q == $past(stage_val))); // R7
endmodule

// File: rtl/atmr_ctrl.sv
module atmr_ctrl
    import atmr_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr,
    input  logic             ctrl_run,
    input  logic             ctrl_arm,
    input  logic             init_wr,
    input  logic             clr_wr,
    input  logic             tick,
    input  logic             up,
    input  logic [CNT_W-1:0] cnt_step,
    input  logic [CNT_W-1:0] alarm_val,
    output logic             run,
    output logic             armed,
    output logic             fire,
    output logic             status
);
    chan_state_e state_q, state_d;
    logic        hit;

    assign hit = up ? (cnt_step >= alarm_val) : (cnt_step <= alarm_val);

    // next-state selection: init, then control write, then alarm disarm
    always_comb begin
        state_d = state_q;
        if (init_wr)
            state_d = ST_HALT_IDLE;
        else if (ctrl_wr)
            state_d = chan_state_e'({ctrl_run, ctrl_arm});
        else begin
            unique case (state_q)
                ST_HALT_IDLE:  state_d = ST_HALT_IDLE;
                ST_HALT_ARMED: state_d = ST_HALT_ARMED;
                ST_RUN_FREE:   state_d = ST_RUN_FREE;
                ST_RUN_ARMED:  state_d = (tick && hit) ? ST_RUN_FREE : ST_RUN_ARMED;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_HALT_IDLE;
        else
            state_q <= state_d;
    end

    // outputs decoded from the current state
    always_comb begin
        run   = 1'b0;
        armed = 1'b0;
        fire  = 1'b0;
        unique case (state_q)
            ST_HALT_IDLE:  ;
            ST_HALT_ARMED: armed = 1'b1;
            ST_RUN_FREE:   run = 1'b1;
            ST_RUN_ARMED: begin
                run   = 1'b1;
                armed = 1'b1;
                fire  = tick && hit;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            status <= 1'b0;
        else if (init_wr)
            status <= 1'b0;
        else if (fire)
            status <= 1'b1;
        else if (clr_wr)
            status <= 1'b0;
    end

    AST_FIRE_SETS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> status); // R6

    AST_FIRE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !ctrl_wr) |=> !armed); // R8

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (status && !clr_wr && !init_wr) |=> status); // R9

    AST_INIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        init_wr |=> (!status && !run && !armed)); // R10
endmodule

// File: rtl/alarm_timer_chan.sv
module alarm_timer_chan
    import atmr_pkg::*;
#(
    parameter int CNT_W = 64,
    parameter int DIV_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data,
    output logic              irq
);
    localparam logic [DIV_W-1:0] DIV_RESET = DIV_W'(2);

    logic             wr_ctrl, wr_div, wr_stage, wr_copy, wr_alarm, wr_stat, wr_init;
    logic             up_q, reload_q, ien_q;
    logic [DIV_W-1:0] div_q;
    logic [CNT_W-1:0] stage_q, alarm_q;
    logic             run, armed, fire, status, tick;
    logic [CNT_W-1:0] cnt_q, cnt_step;
    logic [CTRL_W-1:0] ctrl_rd;

    assign wr_ctrl  = wr_en && (wr_addr == A_CTRL);
    assign wr_div   = wr_en && (wr_addr == A_DIV);
    assign wr_stage = wr_en && (wr_addr == A_STAGE);
    assign wr_copy  = wr_en && (wr_addr == A_COPY);
    assign wr_alarm = wr_en && (wr_addr == A_ALARM);
    assign wr_stat  = wr_en && (wr_addr == A_STAT) && wr_data[0];
    assign wr_init  = wr_en && (wr_addr == A_INIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            up_q     <= 1'b1;
            reload_q <= 1'b0;
            ien_q    <= 1'b0;
            div_q    <= DIV_RESET;
            stage_q  <= '0;
            alarm_q  <= '0;
        end else begin
            if (wr_ctrl) begin
                up_q     <= wr_data[B_UP];
                reload_q <= wr_data[B_RELOAD];
                ien_q    <= wr_data[B_IEN];
            end
            if (wr_div)
                div_q <= wr_data[DIV_W-1:0];
            if (wr_stage)
                stage_q <= wr_data;
            if (wr_alarm)
                alarm_q <= wr_data;
        end
    end

    atmr_prescaler #(.DIV_W(DIV_W)) u_presc (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .restart   (wr_div || wr_init),
        .div_field (div_q),
        .tick      (tick)
    );

    atmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .up        (up_q),
        .fire      (fire),
        .reload_en (reload_q),
        .copy_go   (wr_copy),
        .stage_val (stage_q),
        .cnt_q     (cnt_q),
        .cnt_step  (cnt_step)
    );

    atmr_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (wr_ctrl),
        .ctrl_run  (wr_data[B_RUN]),
        .ctrl_arm  (wr_data[B_ARM]),
        .init_wr   (wr_init),
        .clr_wr    (wr_stat),
        .tick      (tick),
        .up        (up_q),
        .cnt_step  (cnt_step),
        .alarm_val (alarm_q),
        .run       (run),
        .armed     (armed),
        .fire      (fire),
        .status    (status)
    );

    always_comb begin
        ctrl_rd           = '0;
        ctrl_rd[B_RUN]    = run;
        ctrl_rd[B_UP]     = up_q;
        ctrl_rd[B_ARM]    = armed;
        ctrl_rd[B_RELOAD] = reload_q;
        ctrl_rd[B_IEN]    = ien_q;
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_CTRL:  rd_data = CNT_W'(ctrl_rd);
            A_DIV:   rd_data = CNT_W'(div_q);
            A_STAGE: rd_data = stage_q;
            A_ALARM: rd_data = alarm_q;
            A_COUNT: rd_data = cnt_q;
            A_STAT:  rd_data = CNT_W'(status);
            default: rd_data = '0;
        endcase
    end

    assign irq = status && ien_q;

    AST_IRQ_FOLLOWS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !wr_init && !wr_stat && !wr_ctrl) |=> irq); // R11
endmodule

// File: tb/tb_alarm_timer_chan.sv
module tb_alarm_timer_chan;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [63:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [63:0] rd_data;
    logic        irq;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    logic [63:0] exp_q[$];
    bit          pin_q[$];
    string       tag_q[$];

    localparam logic [3:0] A_CTRL = 4'd0, A_DIV = 4'd1, A_STAGE = 4'd2, A_COPY = 4'd3,
                           A_ALARM = 4'd4, A_COUNT = 4'd5, A_STAT = 4'd6, A_INIT = 4'd7;

    always #10 clk = ~clk;

    alarm_timer_chan dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .irq     (irq)
    );

    // monitor: compares queued expectations a quarter period after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #5;
            while (exp_q.size() > 0) begin
                logic [63:0] e, a;
                bit          p;
                string       t;
                e = exp_q.pop_front();
                p = pin_q.pop_front();
                t = tag_q.pop_front();
                a = p ? {63'b0, irq} : rd_data;
                n_checks++;
                if (a !== e) begin
                    n_errors++;
                    $display("FAIL %s: actual=0x%0h expected=0x%0h", t, a, e);
                end
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [63:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic chk(input logic [3:0] a, input logic [63:0] e, input string t);
        rd_addr = a;
        exp_q.push_back(e); pin_q.push_back(1'b0); tag_q.push_back(t);
        @(negedge clk);
    endtask

    task automatic chk_irq(input bit e, input string t);
        exp_q.push_back({63'b0, e}); pin_q.push_back(1'b1); tag_q.push_back(t);
        @(negedge clk);
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // stop, program, then write control; returns one cycle after the control edge
    task automatic setup(input logic [63:0] dv, input logic [63:0] ld,
                         input logic [63:0] al, input logic [63:0] ct);
        wr(A_CTRL, 64'h2);
        wr(A_DIV, dv);
        wr(A_STAGE, ld);
        wr(A_COPY, 64'h0);
        wr(A_ALARM, al);
        wr(A_CTRL, ct);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);

        // R12 reset state
        chk(A_CTRL, 64'h2, "R12 ctrl after reset");
        chk(A_DIV, 64'h2, "R12 divider after reset");
        chk(A_COUNT, 64'h0, "R12 counter after reset");
        chk(A_STAT, 64'h0, "R12 status after reset");
        chk_irq(1'b0, "R12 irq after reset");
        chk(4'hA, 64'h0, "R12 unmapped read");

        // R4 copy while stopped reads back unchanged
        wr(A_STAGE, 64'h3040_5000);
        wr(A_COPY, 64'h0);
        step(5);
        chk(A_COUNT, 64'h3040_5000, "R4 copied value while stopped");
        step(3);
        chk(A_COUNT, 64'h3040_5000, "R4 still held");

        // R1 divide by 4: value at k cycles after run = k/4
        setup(4, 0, 0, 64'h3);
        chk(A_COUNT, 64'd0, "R1 k=0");
        step(2);
        chk(A_COUNT, 64'd0, "R1 k=3");
        chk(A_COUNT, 64'd1, "R1 k=4");
        step(7);
        chk(A_COUNT, 64'd3, "R1 k=12");
        wr(A_CTRL, 64'h2);
        step(10);
        chk(A_COUNT, 64'd3, "R4 hold after pause");

        // R2 field 1 divides by 2, field 0 by 65536
        setup(1, 0, 0, 64'h3);
        step(6);
        chk(A_COUNT, 64'd3, "R2 field 1 -> /2");
        setup(0, 0, 0, 64'h3);
        step(65535);
        chk(A_COUNT, 64'd0, "R2 field 0 before 65536");
        chk(A_COUNT, 64'd1, "R2 field 0 at 65536");

        // R3 divider write restarts the prescaler
        setup(8, 0, 0, 64'h3);
        step(5);
        wr(A_DIV, 3);
        step(2);
        chk(A_COUNT, 64'd0, "R3 before new period");
        chk(A_COUNT, 64'd1, "R3 one new period after write");

        // R5 down count
        setup(2, 10, 0, 64'h1);
        step(6);
        chk(A_COUNT, 64'd7, "R5 down count");

        // R6/R8/R11 up alarm, no reload, irq enabled (ctrl 0x17)
        setup(2, 0, 5, 64'h17);
        step(9);
        chk(A_STAT, 64'd0, "R6 before hit");
        chk(A_STAT, 64'd1, "R6 status on hit");
        chk_irq(1'b1, "R11 irq with enable");
        chk(A_CTRL, 64'h13, "R8 arm bit self-cleared");
        chk(A_COUNT, 64'd6, "R7 no reload counts past alarm");
        step(20);
        chk(A_STAT, 64'd1, "R9 status sticky");
        wr(A_STAT, 64'h1);
        chk(A_STAT, 64'd0, "R9 cleared by write 1");
        chk_irq(1'b0, "R11 irq low after clear");

        // R6/R7/R11 down alarm with reload, irq disabled (ctrl 0x0D)
        setup(2, 20, 17, 64'h0D);
        step(5);
        chk(A_COUNT, 64'd18, "R5 down before hit");
        chk(A_COUNT, 64'd20, "R7 reload on down hit");
        chk(A_STAT, 64'd1, "R6 down compare hit");
        chk_irq(1'b0, "R11 irq gated by enable");
        wr(A_STAT, 64'h1);
        step(6);
        chk(A_STAT, 64'd0, "R8 no status when disarmed");

        // R9 hit beats clear; R10 init
        setup(2, 0, 3, 64'h07);
        step(5);
        wr(A_STAT, 64'h1);
        chk(A_STAT, 64'd1, "R9 hit wins over clear");
        wr(A_INIT, 64'h0);
        chk(A_STAT, 64'd0, "R10 init clears status");
        chk(A_CTRL, 64'h2, "R10 init stops and disarms");
        chk(A_COUNT, 64'd3, "R10 counter kept");
        step(4);
        chk(A_COUNT, 64'd3, "R10 counter stays stopped");

        step(2);
        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule